// File: doc/BRIEF.md
# Firing-Loop Command Decoder

This block sits behind the serial port of a two-loop firing controller. Each 8-bit command that the port accepts as a valid frame arrives here as a one-cycle strobe. The upper nibble selects the operation and the lower nibble carries its data. The block keeps the control state that the analog side uses: high-side switch enables, low-side switch enables, the resistance-measurement path, the analog output selection and the reserve-voltage trip choice. It also prepares the byte that the port shifts out during the following frame.

The byte it prepares depends on the command. A read request returns a snapshot of either the status flags or the fault flags. Any other command is simply echoed back. The switch outputs are always active-high enables, whatever polarity the command encoding uses. The measurement-path and analog-select outputs are one-hot, with all-zero meaning "none" or "high impedance".

Top module: `loop_cmd_decoder`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it rises, all outputs are zero: no switch on, no measurement path, analog output high-Z, low trip level, response byte 0x00.
- R2: Opcode 0x1 loads `resp_byte` with {2'b00, `stat_flags`} as sampled at the strobe. The data nibble has no effect.
- R3: Opcode 0x2 loads `resp_byte` with {4'b0000, `fault_flags`} as sampled at the strobe. The data nibble has no effect.
- R4: Any other accepted command, legal or not, loads `resp_byte` with the command byte itself.
- R5: Opcode 0x3 sets `meas_path` from D1:D0. 01 gives bit 0 (loop 1), 10 gives bit 1 (loop 2), and 00 or 11 gives none.
- R6: Opcode 0x4 sets `amux_sel` to the data nibble when it has at most one bit set. Bit 0 is measurement current, bit 1 is the external input, bit 2 is the battery fraction and bit 3 is the reserve fraction. Any other nibble gives 0000 (high-Z).
- R7: Opcode 0x5 drives the low-side switches with active-low data. D0=0 turns on switch 1 (`ls_on[0]`) and D1=0 turns on switch 2 (`ls_on[1]`).
- R8: Opcode 0xA drives the high-side switches with active-high data. D0=1 turns on switch 1 (`hs_on[0]`) and D1=1 turns on switch 2 (`hs_on[1]`).
- R9: Opcode 0x6 copies D0 to `vres_trip_hi`, where 1 selects the higher reserve trip level.
- R10: Opcodes 0x0, 0x7–0x9 and 0xB–0xF leave every control output unchanged.
- R11: Without `cmd_valid`, no output changes, whatever the command and flag inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle strobe for a valid received command |
| cmd_byte | input | 8 | Received command: opcode in [7:4], data in [3:0] |
| stat_flags | input | 6 | {F1, F2, safing closed, reserve low, battery low, pump low} |
| fault_flags | input | 4 | {SB2, SB1, SG2, SG1} comparator results |
| hs_on | output | 2 | High-side switch enables, bit 0 = loop 1 |
| ls_on | output | 2 | Low-side switch enables, bit 0 = loop 1 |
| meas_path | output | 2 | One-hot resistance measurement path, 0 = none |
| amux_sel | output | 4 | One-hot analog output source, 0 = high-Z |
| vres_trip_hi | output | 1 | Higher reserve-voltage trip level selected |
| resp_byte | output | 8 | Byte to send during the next frame |

## Verification
The assertions assume that `cmd_valid` is only raised for frames that the serial logic has already checked. They also assume that `cmd_byte` and the flag inputs are stable at the clock edge where the strobe is sampled. The bench meets this by changing inputs only on the falling edge and holding the strobe for exactly one rising edge. During idle stretches, the bench deliberately moves `cmd_byte` and the flags while the strobe stays low. This confirms that the control outputs depend only on strobed commands.

// File: rtl/loop_cmd_decoder.sv
module loop_cmd_decoder (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  input  logic [5:0] stat_flags,
  input  logic [3:0] fault_flags,
  output logic [1:0] hs_on,
  output logic [1:0] ls_on,
  output logic [1:0] meas_path,
  output logic [3:0] amux_sel,
  output logic       vres_trip_hi,
  output logic [7:0] resp_byte
);

  localparam logic [3:0] OP_STAT = 4'h1;
  localparam logic [3:0] OP_FLT  = 4'h2;
  localparam logic [3:0] OP_MEAS = 4'h3;
  localparam logic [3:0] OP_AMUX = 4'h4;
  localparam logic [3:0] OP_LOW  = 4'h5;
  localparam logic [3:0] OP_AUX  = 4'h6;
  localparam logic [3:0] OP_HIGH = 4'hA;

  logic [3:0] op, dat;
  logic [1:0] ls_n;
  logic       amux_ok, op_known;

  assign op       = cmd_byte[7:4];
  assign dat      = cmd_byte[3:0];
  assign ls_on    = ~ls_n;
  assign amux_ok  = (dat & (dat - 4'd1)) == 4'd0;
  assign op_known = op inside {OP_STAT, OP_FLT, OP_MEAS, OP_AMUX, OP_LOW, OP_AUX, OP_HIGH};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_on        <= 2'b00;
      ls_n         <= 2'b11;
      meas_path    <= 2'b00;
      amux_sel     <= 4'b0000;
      vres_trip_hi <= 1'b0;
      resp_byte    <= 8'h00;
    end else if (cmd_valid) begin
      case (op)
        OP_MEAS: meas_path    <= (dat[1:0] == 2'b01 || dat[1:0] == 2'b10) ? dat[1:0] : 2'b00;
        OP_AMUX: amux_sel     <= amux_ok ? dat : 4'b0000;
        OP_LOW:  ls_n         <= dat[1:0];
        OP_AUX:  vres_trip_hi <= dat[0];
        OP_HIGH: hs_on        <= dat[1:0];
        default: ;
      endcase
      case (op)
        OP_STAT: resp_byte <= {2'b00, stat_flags};
        OP_FLT:  resp_byte <= {4'b0000, fault_flags};
        default: resp_byte <= cmd_byte;
      endcase
    end
  end

  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (hs_on == 2'b00 && ls_on == 2'b00 && meas_path == 2'b00 &&
                amux_sel == 4'b0000 && !vres_trip_hi && resp_byte == 8'h00));

  a_r2_status_read: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && op == OP_STAT |=> resp_byte == {2'b00, $past(stat_flags)});

  a_r3_fault_read: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && op == OP_FLT |=> resp_byte == {4'b0000, $past(fault_flags)});

  a_r4_echo: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && op != OP_STAT && op != OP_FLT |=> resp_byte == $past(cmd_byte));

  a_r5_meas_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(meas_path));

  a_r6_amux_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(amux_sel));

  a_r7_low_side: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && op == OP_LOW |=> ls_on == ~$past(cmd_byte[1:0]));

  a_r8_high_side: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && op == OP_HIGH |=> hs_on == $past(cmd_byte[1:0]));

  a_r10_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !op_known |=> $stable(hs_on) && $stable(ls_on) && $stable(meas_path) &&
                               $stable(amux_sel) && $stable(vres_trip_hi));

  a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && !cmd_valid |=> $stable(hs_on) && $stable(ls_on) && $stable(meas_path) &&
                   $stable(amux_sel) && $stable(vres_trip_hi) && $stable(resp_byte));

endmodule

// File: tb/test_loop_cmd_decoder.sv
module test_loop_cmd_decoder;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic [5:0] stat_flags = 6'b101101;
  logic [3:0] fault_flags = 4'b1010;
  logic [1:0] hs_on, ls_on, meas_path;
  logic [3:0] amux_sel;
  logic       vres_trip_hi;
  logic [7:0] resp_byte;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  loop_cmd_decoder i_loop_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .stat_flags(stat_flags), .fault_flags(fault_flags), .hs_on(hs_on), .ls_on(ls_on),
    .meas_path(meas_path), .amux_sel(amux_sel), .vres_trip_hi(vres_trip_hi),
    .resp_byte(resp_byte)
  );

  // vector: {cmd, hs, ls, meas, amux, trip, resp}
  localparam int NV = 39;
  localparam logic [26:0] VEC [NV] = '{
    {8'hA3, 2'b11, 2'b00, 2'b00, 4'b0000, 1'b0, 8'hA3},
    {8'h51, 2'b11, 2'b10, 2'b00, 4'b0000, 1'b0, 8'h51},
    {8'h50, 2'b11, 2'b11, 2'b00, 4'b0000, 1'b0, 8'h50},
    {8'h52, 2'b11, 2'b01, 2'b00, 4'b0000, 1'b0, 8'h52},
    {8'h53, 2'b11, 2'b00, 2'b00, 4'b0000, 1'b0, 8'h53},
    {8'hA1, 2'b01, 2'b00, 2'b00, 4'b0000, 1'b0, 8'hA1},
    {8'hA2, 2'b10, 2'b00, 2'b00, 4'b0000, 1'b0, 8'hA2},
    {8'hA0, 2'b00, 2'b00, 2'b00, 4'b0000, 1'b0, 8'hA0},
    {8'h31, 2'b00, 2'b00, 2'b01, 4'b0000, 1'b0, 8'h31},
    {8'h32, 2'b00, 2'b00, 2'b10, 4'b0000, 1'b0, 8'h32},
    {8'h33, 2'b00, 2'b00, 2'b00, 4'b0000, 1'b0, 8'h33},
    {8'h31, 2'b00, 2'b00, 2'b01, 4'b0000, 1'b0, 8'h31},
    {8'h30, 2'b00, 2'b00, 2'b00, 4'b0000, 1'b0, 8'h30},
    {8'h41, 2'b00, 2'b00, 2'b00, 4'b0001, 1'b0, 8'h41},
    {8'h42, 2'b00, 2'b00, 2'b00, 4'b0010, 1'b0, 8'h42},
    {8'h44, 2'b00, 2'b00, 2'b00, 4'b0100, 1'b0, 8'h44},
    {8'h48, 2'b00, 2'b00, 2'b00, 4'b1000, 1'b0, 8'h48},
    {8'h43, 2'b00, 2'b00, 2'b00, 4'b0000, 1'b0, 8'h43},
    {8'h44, 2'b00, 2'b00, 2'b00, 4'b0100, 1'b0, 8'h44},
    {8'h4C, 2'b00, 2'b00, 2'b00, 4'b0000, 1'b0, 8'h4C},
    {8'h48, 2'b00, 2'b00, 2'b00, 4'b1000, 1'b0, 8'h48},
    {8'h4F, 2'b00, 2'b00, 2'b00, 4'b0000, 1'b0, 8'h4F},
    {8'h61, 2'b00, 2'b00, 2'b00, 4'b0000, 1'b1, 8'h61},
    {8'h6E, 2'b00, 2'b00, 2'b00, 4'b0000, 1'b0, 8'h6E},
    {8'h6F, 2'b00, 2'b00, 2'b00, 4'b0000, 1'b1, 8'h6F},
    {8'h1F, 2'b00, 2'b00, 2'b00, 4'b0000, 1'b1, 8'h2D},
    {8'h2F, 2'b00, 2'b00, 2'b00, 4'b0000, 1'b1, 8'h0A},
    {8'h10, 2'b00, 2'b00, 2'b00, 4'b0000, 1'b1, 8'h2D},
    {8'hA3, 2'b11, 2'b00, 2'b00, 4'b0000, 1'b1, 8'hA3},
    {8'h52, 2'b11, 2'b01, 2'b00, 4'b0000, 1'b1, 8'h52},
    {8'h32, 2'b11, 2'b01, 2'b10, 4'b0000, 1'b1, 8'h32},
    {8'h42, 2'b11, 2'b01, 2'b10, 4'b0010, 1'b1, 8'h42},
    {8'h7F, 2'b11, 2'b01, 2'b10, 4'b0010, 1'b1, 8'h7F},
    {8'h00, 2'b11, 2'b01, 2'b10, 4'b0010, 1'b1, 8'h00},
    {8'h9C, 2'b11, 2'b01, 2'b10, 4'b0010, 1'b1, 8'h9C},
    {8'hF0, 2'b11, 2'b01, 2'b10, 4'b0010, 1'b1, 8'hF0},
    {8'hB5, 2'b11, 2'b01, 2'b10, 4'b0010, 1'b1, 8'hB5},
    {8'h8A, 2'b11, 2'b01, 2'b10, 4'b0010, 1'b1, 8'h8A},
    {8'hE1, 2'b11, 2'b01, 2'b10, 4'b0010, 1'b1, 8'hE1}
  };

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'h1: return "R2";
      4'h2: return "R3";
      4'h3: return "R5";
      4'h4: return "R6";
      4'h5: return "R7";
      4'h6: return "R9";
      4'hA: return "R8";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [18:0] snap();
    return {hs_on, ls_on, meas_path, amux_sel, vres_trip_hi, resp_byte};
  endfunction

  task automatic check(input string req, input logic [18:0] act, input logic [18:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] c);
    @(negedge clk);
    cmd_byte  = c;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [18:0] held;
    repeat (3) @(negedge clk);
    check("R1", snap(), 19'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", snap(), 19'd0);

    for (int k = 0; k < NV; k++) begin
      send(VEC[k][26:19]);
      check(req_of(VEC[k][26:23]), snap(), VEC[k][18:0]);
      if (VEC[k][26:23] != 4'h1 && VEC[k][26:23] != 4'h2)
        check("R4", {11'd0, resp_byte}, {11'd0, VEC[k][26:19]});
    end

    // R11: inputs move without the strobe
    held = snap();
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      cmd_byte    = 8'h10 + 8'(k * 17);
      stat_flags  = ~stat_flags;
      fault_flags = ~fault_flags;
    end
    @(negedge clk);
    check("R11", snap(), held);

    // R2 with changed flags, snapshot taken at the strobe
    stat_flags = 6'b010011;
    send(8'h1A);
    stat_flags = 6'b111111;
    @(negedge clk);
    check("R2", {11'd0, resp_byte}, {11'd0, 8'h13});

    // R1: reset again from a busy state
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", snap(), 19'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", snap(), 19'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule